// File: doc/BRIEF.md
# Single-Wire Slave Network Command Controller

This block is the network-command layer of a slave on a single-wire, open-drain bus. A bit-slot layer below it turns the line waveform into single-cycle strobes:
- a detected bus reset;
- a received bit with its valid strobe;
- a read-slot request, when the master opens a slot for the slave to answer.

After every bus reset the block asks for a presence pulse. It then collects an 8-bit command, least-significant bit first. The command selects one of two actions:
- Code 33h: the block returns its 64-bit identity over the next 64 read slots. The identity is the family byte, then the 48-bit serial number, then a CRC byte.
- Code 55h: the block compares the next 64 written bits with its identity.

A full read or a full match raises `select`, which grants the memory-command stage access until the next bus reset. A mismatch or an unknown code makes the block silent until the next bus reset.

The bit stream cannot be back-pressured, because bus timing cannot wait. Every strobe is therefore consumed in the cycle it arrives, and no ready signal exists. The transmit side only ever asks for the line to be pulled low. Under the wired-AND bus, a released line reads as one, so several slaves answering the same slot combine their bits.

Top module: `owrom_ctrl`

## Requirements
- R1: One cycle after a cycle with `reset_det` high, `presence_req` is high for exactly that cycle, whatever state the block was in.
- R2: After a bus reset the block takes the next 8 bits received with `rx_valid` high as the command, least-significant bit first. Cycles without `rx_valid` do not count, and the value on `rx_bit` in those cycles is ignored.
- R3: After command 33h, each `rd_req` strobe makes `pull_low` high in the next cycle exactly when the current identity bit is 0. Bits go out in identity order, LSB first: family byte, then serial bits 0..47, then CRC byte.
- R4: `select` rises the cycle after the 64th read slot of a 33h command.
- R5: After command 55h, the block compares 64 received bits with its identity in the order of R3. If all 64 agree, `select` rises the cycle after the last bit and stays high until the next bus reset.
- R6: After a compare mismatch, the block ignores all further bits and read slots until the next bus reset. During that time `select` and `pull_low` stay low.
- R7: A command code other than 33h or 55h leaves the block silent in the same way as R6.
- R8: A bus reset aborts any operation. In the next cycle `select` is low and command collection restarts from bit 0.
- R9: `pull_low` is only ever high in the cycle after an `rd_req` strobe that arrived during the read phase of a 33h command.
- R10: The identity CRC byte is the CRC of the first 56 identity bits, fed LSB first, using polynomial x^8+x^5+x^4+1 (reflected constant 8Ch) with an initial value of 0.
- R11: While `rst_n` is low, `presence_req`, `pull_low` and `select` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_det | input | 1 | Single-cycle strobe: bus reset seen |
| rx_valid | input | 1 | Single-cycle strobe: `rx_bit` holds a received bit |
| rx_bit | input | 1 | Received bit value |
| rd_req | input | 1 | Single-cycle strobe: master opened a read slot |
| presence_req | output | 1 | Request to send a presence pulse |
| pull_low | output | 1 | Request to hold the line low for the current read slot |
| select | output | 1 | Access granted to the memory-command stage |

## Verification
The assertions assume that `reset_det`, `rx_valid` and `rd_req` are single-cycle strobes from the slot layer. They also assume that `rx_valid` and `rd_req` never arrive in the same cycle, since one slot carries one direction. The stimulus drives every strobe for exactly one cycle and separates strobes by at least one quiet cycle. Between bits it changes `rx_bit` to the opposite value, so any sampling without `rx_valid` shows up as a wrong command or a wrong match result.

// File: rtl/owrom_pkg.sv
package owrom_pkg;

  localparam int FAM_W = 8;
  localparam int SER_W = 48;
  localparam int CRC_W = 8;
  localparam int ID_W  = FAM_W + SER_W + CRC_W;
  localparam int CMD_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_SEND,
    ST_MATCH,
    ST_SEL
  } owrom_state_e;

  // CRC over the first 56 identity bits, LSB first, reflected poly 8Ch
  function automatic logic [CRC_W-1:0] id_crc(input logic [FAM_W+SER_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = 0; i < FAM_W + SER_W; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

endpackage

// File: rtl/owrom_cmd_rx.sv
module owrom_cmd_rx #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic             bit_in,
  output logic             done,
  output logic [CMD_W-1:0] code
);
  localparam int CNT_W = $clog2(CMD_W);

  logic [CMD_W-1:0] shreg;
  logic [CNT_W-1:0] cnt;

  assign code = {bit_in, shreg[CMD_W-1:1]};
  assign done = take && (cnt == CNT_W'(CMD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (clear) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (take) begin
      shreg <= code;
      cnt   <= done ? '0 : cnt + 1'b1;
    end
  end

  // R2: a clear always restarts collection at bit 0
  p_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt == '0);
  // R2: cycles without a strobe leave the collection untouched
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clear) |=> ($stable(cnt) && $stable(shreg)));

endmodule

// File: rtl/owrom_id_port.sv
module owrom_id_port #(
  parameter int          ID_W   = 64,
  parameter logic [63:0] ID_VAL = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic cur_bit,
  output logic at_last
);
  localparam int IDX_W = $clog2(ID_W);

  logic [IDX_W-1:0] idx;

  assign cur_bit = ID_VAL[idx];
  assign at_last = (idx == IDX_W'(ID_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (clear)   idx <= '0;
    else if (step)    idx <= at_last ? '0 : idx + 1'b1;
  end

  // R3: the identity pointer only moves on a step
  p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(idx));
  // R8: a clear restarts at the family byte's first bit
  p_idx_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> idx == '0);

endmodule

// File: rtl/owrom_ctrl.sv
module owrom_ctrl #(
  parameter logic [7:0]  FAMILY     = 8'h04,
  parameter logic [47:0] SERIAL     = 48'h0000_0000_0001,
  parameter logic [7:0]  READ_CODE  = 8'h33,
  parameter logic [7:0]  MATCH_CODE = 8'h55
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reset_det,
  input  logic rx_valid,
  input  logic rx_bit,
  input  logic rd_req,
  output logic presence_req,
  output logic pull_low,
  output logic select
);
  import owrom_pkg::*;

  localparam logic [CRC_W-1:0] CRC_VAL = id_crc({SERIAL, FAMILY});
  localparam logic [ID_W-1:0]  ID_VAL  = {CRC_VAL, SERIAL, FAMILY};

  owrom_state_e state, nxt;

  logic             cmd_take, cmd_done;
  logic [CMD_W-1:0] cmd_code;
  logic             id_clr, id_step, id_bit, id_last;
  logic             pull_nxt;

  assign cmd_take = rx_valid && (state == ST_CMD) && !reset_det;

  owrom_cmd_rx #(.CMD_W(CMD_W)) u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (reset_det),
    .take   (cmd_take),
    .bit_in (rx_bit),
    .done   (cmd_done),
    .code   (cmd_code)
  );

  owrom_id_port #(.ID_W(ID_W), .ID_VAL(ID_VAL)) u_id (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (id_clr),
    .step    (id_step),
    .cur_bit (id_bit),
    .at_last (id_last)
  );

  always_comb begin
    nxt      = state;
    id_clr   = 1'b0;
    id_step  = 1'b0;
    pull_nxt = 1'b0;
    if (reset_det) begin
      nxt    = ST_CMD;
      id_clr = 1'b1;
    end else begin
      case (state)
        ST_CMD: begin
          if (cmd_done) begin
            if (cmd_code == READ_CODE)       nxt = ST_SEND;
            else if (cmd_code == MATCH_CODE) nxt = ST_MATCH;
            else                             nxt = ST_IDLE;
          end
        end
        ST_SEND: begin
          if (rd_req) begin
            pull_nxt = ~id_bit;
            id_step  = 1'b1;
            if (id_last) nxt = ST_SEL;
          end
        end
        ST_MATCH: begin
          if (rx_valid) begin
            if (rx_bit != id_bit) begin
              nxt = ST_IDLE;
            end else begin
              id_step = 1'b1;
              if (id_last) nxt = ST_SEL;
            end
          end
        end
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      presence_req <= 1'b0;
      pull_low     <= 1'b0;
    end else begin
      state        <= nxt;
      presence_req <= reset_det;
      pull_low     <= pull_nxt;
    end
  end

  assign select = (state == ST_SEL);

  // R1: every detected bus reset is answered by a presence request
  p_presence_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reset_det |=> presence_req);
  // R8: a bus reset withdraws the grant
  p_sel_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_det |=> !select);
  // R5: once granted, access persists until a bus reset
  p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (select && !reset_det) |=> select);
  // R6: the silent state is left only through a bus reset
  p_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !reset_det) |=> (state == ST_IDLE && !pull_low && !select));
  // R9: a line pull only follows a read slot
  p_pull_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low |-> $past(rd_req));
  // R9: no pull is requested while access is granted
  p_pull_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (select && $past(select)) |-> !pull_low);

endmodule

// File: tb/tb_owrom_ctrl.sv
module tb_owrom_ctrl;

  localparam logic [7:0]  FAM = 8'h26;
  localparam logic [47:0] SER = 48'h00A1_B2C3_D4E5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reset_det = 1'b0, rx_valid = 1'b0, rx_bit = 1'b0, rd_req = 1'b0;
  logic presence_req, pull_low, select;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  owrom_ctrl #(.FAMILY(FAM), .SERIAL(SER)) dut (
    .clk(clk), .rst_n(rst_n), .reset_det(reset_det), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .rd_req(rd_req), .presence_req(presence_req),
    .pull_low(pull_low), .select(select)
  );

  // independent CRC: shift register form, one bit at a time
  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] r = 8'h00;
    for (int k = 0; k < 56; k++) begin
      if (r[0] ^ d[k]) r = (r >> 1) ^ 8'h8C;
      else             r = r >> 1;
    end
    return r;
  endfunction

  logic [63:0] exp_id;
  initial exp_id = {ref_crc({SER, FAM}), SER, FAM};

  // behavioural reference model
  int   m_phase = 0;   // 0 silent, 1 command, 2 read, 3 compare, 4 granted
  int   m_cnt = 0;
  int   m_code = 0;
  logic m_pres = 0, m_pull = 0, m_sel = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_code = 0; m_pres = 0; m_pull = 0;
    end else begin
      m_pres = reset_det;
      m_pull = 0;
      if (reset_det) begin
        m_phase = 1; m_cnt = 0; m_code = 0;
      end else if (m_phase == 1 && rx_valid) begin
        m_code = m_code | (int'(rx_bit) << m_cnt);
        m_cnt++;
        if (m_cnt == 8) begin
          m_phase = (m_code == 'h33) ? 2 : (m_code == 'h55) ? 3 : 0;
          m_cnt = 0;
        end
      end else if (m_phase == 2 && rd_req) begin
        m_pull = !exp_id[m_cnt];
        m_cnt++;
        if (m_cnt == 64) m_phase = 4;
      end else if (m_phase == 3 && rx_valid) begin
        if (rx_bit != exp_id[m_cnt]) m_phase = 0;
        else begin
          m_cnt++;
          if (m_cnt == 64) m_phase = 4;
        end
      end
    end
    m_sel = (m_phase == 4);
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    chk("R1 presence", presence_req, m_pres);
    chk("R9 pull_low", pull_low, m_pull);
    chk("R5 select", select, m_sel);
  end

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reset_det = 0; rx_valid = 0; rd_req = 0;
    end
  endtask

  task automatic bus_reset;
    @(negedge clk); reset_det = 1;
    @(negedge clk); reset_det = 0;
  endtask

  task automatic wbit(input logic b, input int gap);
    @(negedge clk); rx_valid = 1; rx_bit = b;
    @(negedge clk); rx_valid = 0; rx_bit = ~b;
    quiet(gap);
  endtask

  task automatic wbyte(input logic [7:0] v, input int gap);
    for (int i = 0; i < 8; i++) wbit(v[i], gap);
  endtask

  task automatic wid(input logic [63:0] v);
    for (int i = 0; i < 64; i++) wbit(v[i], 0);
  endtask

  task automatic rslot(output logic b);
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0; b = !pull_low;
  endtask

  initial begin
    logic [63:0] got;
    logic        bb;
    logic        seen_pull;
    quiet(3);
    chk("R11 presence in reset", presence_req, 1'b0);
    chk("R11 pull in reset", pull_low, 1'b0);
    chk("R11 select in reset", select, 1'b0);
    rst_n = 1;
    quiet(2);

    // read identity; command sent with gaps and garbage between bits
    bus_reset();
    chk("R1 presence after reset", presence_req, 1'b1);
    wbyte(8'h33, 2);
    chk("R2 gapped command", select, 1'b0);
    for (int i = 0; i < 64; i++) begin
      rslot(bb);
      got[i] = bb;
      if (i == 62) chk("R4 no select before last slot", select, 1'b0);
    end
    chk64("R3 identity stream", got, exp_id);
    chk("R10 crc consistent", got[63:56] === ref_crc(got[55:0]), 1'b1);
    chk("R4 select after read", select, 1'b1);
    rslot(bb);
    chk("R9 no pull when granted", pull_low, 1'b0);

    // successful match
    bus_reset();
    chk("R8 select dropped", select, 1'b0);
    wbyte(8'h55, 0);
    wid(exp_id);
    chk("R5 select after match", select, 1'b1);
    quiet(3);
    chk("R5 select held", select, 1'b1);

    // mismatch at bit 20
    bus_reset();
    wbyte(8'h55, 1);
    got = exp_id; got[20] = ~got[20];
    wid(got);
    chk("R6 no select after mismatch", select, 1'b0);
    seen_pull = 0;
    for (int i = 0; i < 8; i++) begin rslot(bb); seen_pull |= !bb; end
    chk("R6 silent on read slots", seen_pull, 1'b0);
    wbyte(8'h33, 0);
    chk("R6 command ignored", select, 1'b0);

    // unknown code
    bus_reset();
    wbyte(8'hA5, 0);
    seen_pull = 0;
    for (int i = 0; i < 8; i++) begin rslot(bb); seen_pull |= !bb; end
    chk("R7 silent after unknown code", seen_pull, 1'b0);
    wid(exp_id);
    chk("R7 no select", select, 1'b0);

    // abort mid-read, then full match
    bus_reset();
    wbyte(8'h33, 0);
    for (int i = 0; i < 10; i++) rslot(bb);
    wbit(1'b1, 0);
    bus_reset();
    chk("R8 presence on abort", presence_req, 1'b1);
    wbyte(8'h55, 0);
    wid(exp_id);
    chk("R8 restart from bit 0", select, 1'b1);

    // reset in the middle of a command
    bus_reset();
    wbit(1'b1, 0); wbit(1'b1, 0); wbit(1'b0, 0);
    bus_reset();
    wbyte(8'h33, 0);
    for (int i = 0; i < 64; i++) begin rslot(bb); got[i] = bb; end
    chk64("R8 command restarts", got, exp_id);

    quiet(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule